// File: doc/BRIEF.md
# TDM Channel Control Bit Serializer

This block drives two serial control lines that tell external bus buffers, channel by channel, whether each of sixteen time-division output streams should be driven or left in high impedance. Each line runs at one bit per output-clock period (16.384 Mb/s) on a 2048-period frame. Line 0 serves the even-numbered streams and line 1 the odd-numbered ones. Eight streams share a line by taking turns, one period each, in a repeating group of eight periods. The groups are aligned so that the slot of stream 0 falls nine periods before the frame boundary.

Each stream has its own data-rate code. A slower stream has fewer channels per frame, so its enable bit is held for several consecutive groups: 1, 2, 4 or 8 groups. The bits come from an external enable store through a simple read port with one cycle of read latency. The block presents the slot and a channel number for each line and takes back one bit per line. A static strap input, passed through a synchronizer, states whether the stream outputs are tristated inside the device or by external buffers that follow these lines.

Top module: `chctl_serializer`

## Requirements
- R1: From reset both control lines are low (all channels in high impedance). They stay low until the first frame pulse, and also through periods 0 and 1 of the first frame. From period 2 of that frame they carry data.
- R2: When `frame_i` is sampled high at a rising edge, the period that follows is period 0. Otherwise the period index advances by one per clock and wraps from 2047 to 0.
- R3: In period p the active slot is k = ((p + 9) mod 2048) mod 8. Line 0 (`ctl_line_o[0]`) carries stream 2k and line 1 (`ctl_line_o[1]`) carries stream 2k+1. So stream 0 and stream 1 are sent in period 2039, stream 14 and stream 15 in period 2046, and the streams follow in ascending order.
- R4: In period p the group is g = ((p + 9) mod 2048) div 8. The channel sent is g shifted right by 3 − c, where c is the stream's 2-bit rate code in `rate_i[2s+1:2s]`. The codes are: 0 = 2.048 Mb/s (each bit held 8 groups), 1 = 4.096 Mb/s (4 groups), 2 = 8.192 Mb/s (2 groups), 3 = 16.384 Mb/s (1 group).
- R5: The line level equals the stored enable bit for that stream and channel. A stored 1 gives a high level (drive). A stored 0 gives a low level (high impedance).
- R6: The block presents `rd_slot_o`, `rd_chan_even_o` and `rd_chan_odd_o` two cycles before the period they serve. The store answers on `rd_bit_i` one cycle after the address: bit 0 for the even stream, bit 1 for the odd stream.
- R7: For stream 2 at code 0, the channel 0 bit appears on line 0 in periods 2040, 0, 8, 16, 24, 32, 40 and 48, and in no other period.
- R8: `int_hiz_o` follows `strap_i` through two flops. A change becomes visible after the second rising edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Output clock, one period per line bit |
| rst_ni | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | Frame pulse; the period after the edge that samples it high is period 0 |
| strap_i | input | 1 | Asynchronous mode strap: 1 = internal per-channel tristate |
| rate_i | input | 32 | Two-bit rate code per stream, stream s at bits 2s+1:2s |
| rd_slot_o | output | 3 | Slot index k being fetched (streams 2k and 2k+1) |
| rd_chan_even_o | output | 8 | Channel to read for stream 2k |
| rd_chan_odd_o | output | 8 | Channel to read for stream 2k+1 |
| rd_bit_i | input | 2 | Enable bits returned one cycle after the address |
| ctl_line_o | output | 2 | Serial control lines (bit 0 even streams, bit 1 odd streams) |
| int_hiz_o | output | 1 | Synchronized strap |

## Verification
A line bit for period p comes from an address presented two clocks earlier. The store model answers one edge later, and the output flop adds one more edge. The bench therefore keeps its own period count, which it advances at each falling edge after the frame pulse edge. It compares both lines against the stream, channel and rate decode for that same period index. Any change to the enable pattern or to the rates is followed by one unchecked frame, so that bits already fetched do not count against the new setting. The strap is checked one falling edge after the first rising edge, where it must be unchanged, and one falling edge after the second, where it must have changed.

// File: rtl/chctl_pkg.sv
// Shared types for the channel control serializer.
// Assumes four rate codes, ordered slowest to fastest.
package chctl_pkg;
    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_16M = 2'd3
    } rate_e;

    // Right shift that maps a group index to a channel index for a rate code.
    function automatic logic [1:0] rep_shift(input logic [1:0] code);
        return 2'd3 - code;
    endfunction
endpackage

// File: rtl/chctl_period_cnt.sv
// Free-running frame period counter.
// The counter reloads to 0 for the period that follows an edge where
// frame_i is high. It also records that a first frame pulse has arrived.
// Assumes frame_i is synchronous to clk_i.
module chctl_period_cnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_i,
    output logic [CNT_W-1:0] per_o,
    output logic             started_o
);
    // Period index: reload on frame pulse, otherwise count and wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      per_o <= '0;
        else if (frame_i) per_o <= '0;
        else              per_o <= per_o + 1'b1;
    end

    // Sticky flag: a frame pulse has been seen since reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      started_o <= 1'b0;
        else if (frame_i) started_o <= 1'b1;
    end

    a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_i |=> per_o == '0);
    a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> per_o == CNT_W'($past(per_o) + 1'b1));
    a_r1_started_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        started_o |=> started_o);
endmodule

// File: rtl/chctl_chan_sel.sv
// Channel selector for one control line.
// The stream is {slot, LINE}. Its rate code picks how far the group index
// is shifted right to give the channel. Purely combinational.
module chctl_chan_sel
    import chctl_pkg::*;
#(
    parameter int SLOT_W = 3,
    parameter int CH_W   = 8,
    parameter int LINE   = 0,
    localparam int STREAMS = 2 << SLOT_W
) (
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic [CH_W-1:0]      grp_i,
    input  logic [2*STREAMS-1:0] rate_i,
    output logic [CH_W-1:0]      chan_o
);
    logic [SLOT_W:0] strm;
    logic [1:0]      code;

    // Decode the stream's rate code and fold repeated groups onto one channel.
    always_comb begin
        strm   = {slot_i, LINE[0]};
        code   = rate_i[2*strm +: 2];
        chan_o = grp_i >> rep_shift(code);
        a_r4_chan_range: assert ((32'(chan_o) >> (CH_W - 3 + 32'(code))) == 0);
    end
endmodule

// File: rtl/chctl_strap_sync.sv
// Two-flop synchronizer for the asynchronous mode strap.
// Assumes the strap is quasi-static.
module chctl_strap_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strap_i,
    output logic strap_o
);
    logic meta_q;

    // Two flops in series retime the strap into clk_i.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q  <= 1'b0;
            strap_o <= 1'b0;
        end else begin
            meta_q  <= strap_i;
            strap_o <= meta_q;
        end
    end
endmodule

// File: rtl/chctl_serializer.sv
// Top level of the channel control serializer.
// Computes the fetch position two periods ahead: one cycle for the store's
// read latency and one for the output flop. It addresses the enable store
// for both lines and registers the returned bits onto the lines.
// Assumes frame pulses are 2048 periods apart once running.
module chctl_serializer #(
    parameter int CNT_W   = 11,
    parameter int SLOT_W  = 3,
    parameter int ADVANCE = 9,
    localparam int CH_W    = CNT_W - SLOT_W,
    localparam int LINES   = 2,
    localparam int STREAMS = LINES << SLOT_W,
    localparam int LEAD    = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 frame_i,
    input  logic                 strap_i,
    input  logic [2*STREAMS-1:0] rate_i,
    output logic [SLOT_W-1:0]    rd_slot_o,
    output logic [CH_W-1:0]      rd_chan_even_o,
    output logic [CH_W-1:0]      rd_chan_odd_o,
    input  logic [LINES-1:0]     rd_bit_i,
    output logic [LINES-1:0]     ctl_line_o,
    output logic                 int_hiz_o
);
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] pos;
    logic [CH_W-1:0]  grp;
    logic [CH_W-1:0]  chan [LINES];
    logic             started;
    logic             run_q;

    chctl_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .frame_i   (frame_i),
        .per_o     (per_q),
        .started_o (started)
    );

    // Fetch position: period served two cycles from now, shifted by the lead.
    always_comb begin
        pos       = per_q + CNT_W'(LEAD + ADVANCE);
        rd_slot_o = pos[SLOT_W-1:0];
        grp       = pos[CNT_W-1:SLOT_W];
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        chctl_chan_sel #(.SLOT_W(SLOT_W), .CH_W(CH_W), .LINE(l)) u_sel (
            .slot_i (rd_slot_o),
            .grp_i  (grp),
            .rate_i (rate_i),
            .chan_o (chan[l])
        );
    end

    assign rd_chan_even_o = chan[0];
    assign rd_chan_odd_o  = chan[1];

    // Output flop: lines stay low until data fetched after the first pulse returns.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q      <= 1'b0;
            ctl_line_o <= '0;
        end else begin
            run_q      <= started;
            ctl_line_o <= run_q ? rd_bit_i : '0;
        end
    end

    chctl_strap_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strap_i (strap_i),
        .strap_o (int_hiz_o)
    );

    a_r1_low_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !started |=> ctl_line_o == '0);
    a_r3_slot_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> rd_slot_o == SLOT_W'($past(rd_slot_o) + 1'b1));
endmodule

// File: tb/chctl_serializer_test.sv
`timescale 1ns/1ps
module chctl_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame = 1'b0;
    logic        strap = 1'b0;
    logic [31:0] rate = '0;
    logic [2:0]  rd_slot;
    logic [7:0]  rd_chan_e, rd_chan_o;
    logic [1:0]  rd_bit;
    logic [1:0]  line;
    logic        hiz;

    logic mem [16][256];
    int   checks = 0;
    int   fails  = 0;
    int   p      = 0;
    bit   done   = 0;

    always #2.5 clk = ~clk;

    chctl_serializer uut (
        .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .strap_i(strap),
        .rate_i(rate), .rd_slot_o(rd_slot), .rd_chan_even_o(rd_chan_e),
        .rd_chan_odd_o(rd_chan_o), .rd_bit_i(rd_bit), .ctl_line_o(line),
        .int_hiz_o(hiz)
    );

    // Enable store model: one cycle read latency (R6).
    always_ff @(posedge clk) begin
        rd_bit[0] <= mem[{rd_slot, 1'b0}][rd_chan_e];
        rd_bit[1] <= mem[{rd_slot, 1'b1}][rd_chan_o];
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s period %0d: got %b expected %b", tag, p, act, exp);
        end
    endtask

    // Expected line level for period per on line ln (R3, R4, R5).
    function automatic logic model(int per, int ln);
        int q = (per + 9) % 2048;
        int s = 2 * (q % 8) + ln;
        int c = int'(rate[2*s +: 2]);
        int ch = (q / 8) >> (3 - c);
        return mem[s][ch];
    endfunction

    // One period: frame pulse driven in period 2047 (R2).
    task automatic tick();
        frame = (p == 2047);
        @(posedge clk);
        @(negedge clk);
        p = (p + 1) % 2048;
    endtask

    task automatic fill(int seed);
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 256; c++)
                mem[s][c] = (((s * 7 + c * 3 + (c >> 1) + seed) % 5) < 3);
    endtask

    task automatic clear_mem();
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 256; c++)
                mem[s][c] = 1'b0;
    endtask

    task automatic settle_frame();
        repeat (2048) tick();
    endtask

    task automatic check_frame(string tag);
        repeat (2048) begin
            tick();
            check(tag, line[0], model(p, 0));
            check(tag, line[1], model(p, 1));
        end
    endtask

    // R1, R8: quiet after reset, no frame pulse yet.
    task automatic t_reset_quiet();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            check("R1", line[0], 1'b0);
            check("R1", line[1], 1'b0);
        end
        check("R8", hiz, 1'b0);
    endtask

    // R1, R4, R5, R6: first frame after the first pulse.
    task automatic t_first_frame();
        p = 2047;
        tick();
        check("R1", line[0], 1'b0);
        check("R1", line[1], 1'b0);
        tick();
        check("R1", line[0], 1'b0);
        check("R1", line[1], 1'b0);
        repeat (2046) begin
            tick();
            check("R4", line[0], model(p, 0));
            check("R4", line[1], model(p, 1));
        end
    endtask

    // R3: stream 14 and 15 channel 0 only, all fast -> high only in period 2046.
    task automatic t_slot_position();
        clear_mem();
        rate = '1;
        mem[14][0] = 1'b1;
        mem[15][0] = 1'b1;
        settle_frame();
        repeat (2048) begin
            tick();
            check("R3", line[0], p == 2046);
            check("R3", line[1], p == 2046);
        end
    endtask

    // R7: stream 2 at the slowest rate, channel 0 only set.
    task automatic t_slow_stream2();
        clear_mem();
        rate = '1;
        rate[5:4] = 2'd0;
        mem[2][0] = 1'b1;
        settle_frame();
        repeat (2048) begin
            tick();
            check("R7", line[0], (p == 2040) || (p <= 48 && p % 8 == 0));
            check("R7", line[1], 1'b0);
        end
    endtask

    // R8: strap visible after the second edge only.
    task automatic t_strap();
        strap = 1'b1;
        tick();
        check("R8", hiz, 1'b0);
        tick();
        check("R8", hiz, 1'b1);
        strap = 1'b0;
        tick();
        check("R8", hiz, 1'b1);
        tick();
        check("R8", hiz, 1'b0);
    endtask

    initial begin
        fill(0);
        for (int s = 0; s < 16; s++) rate[2*s +: 2] = 2'((s * 3 + 1) % 4);
        t_reset_quiet();
        t_first_frame();
        fill(2);
        settle_frame();
        check_frame("R5 R6");
        t_slot_position();
        t_slow_stream2();
        t_strap();
        fill(4);
        rate = '0;
        settle_frame();
        check_frame("R4");
        for (int s = 0; s < 16; s++) rate[2*s +: 2] = 2'(3 - (s % 4));
        settle_frame();
        check_frame("R4");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule